// File: doc/BRIEF.md
# Four-Channel DAC Command Register Bank

This block is the digital control core of a four-channel, double-buffered digital-to-analog converter. An upstream serial receiver hands it one fully assembled 24-bit command word per transfer. The word carries an operation code, a channel address and a 16-bit data word. Each channel has a staging (input) register, an active register that drives the converter, and an enable flag that is low while the channel is powered down. A channel that is woken by an update raises a busy flag for a settling window counted in clock cycles. The window is longer when every channel was asleep before the update.

The command intake is a valid/ready stream. `cmd_ready` is high whenever the block is out of reset. The block never applies back-pressure: a busy channel does not stall commands, and every word offered with `cmd_valid` high is taken at that rising edge. Its effect shows on the outputs right after that edge. Active codes can be narrowed to 12, 14 or 16 bits. The upper bits of the data word are kept and the rest are dropped.

Top module: `quad_dac_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, every active code reads 0, every enable flag and busy flag is 0, and `cmd_ready` is 0 in reset and 1 afterwards.
- R2: Operation 0000 stores the data word in the staging register of the addressed channel(s) only. Active codes, enables and busy flags are not changed.
- R3: Operation 0001 copies the staging register of the addressed channel(s) into the active register and sets their enable flag.
- R4: Operation 0010 stores the data word in the staging register of the addressed channel(s), then updates and enables all four channels from their staging registers.
- R5: Operation 0011 stores the data word and makes it active on the addressed channel(s) in the same edge, and enables them.
- R6: Operation 0100 clears the enable and busy flags of the addressed channel(s). The data word is ignored, and staging and active registers keep their contents. A later 0001 restores the old values.
- R7: Operation 1111 is a no-operation. Operation codes 0101 to 1110 and address codes 0100 to 1110 change no state.
- R8: Address 0000, 0001, 0010 and 0011 select channels A to D. Address 1111 selects all four at once.
- R9: With resolution RES, the active code is data bits [15:16-RES], and the lower bits are don't-care. Channel c drives `dac_code[c*RES +: RES]`.
- R10: An update that enables a channel which was down, while at least one channel was enabled, holds that channel's busy flag high for exactly PU_CYC cycles after the edge.
- R11: If all channels were down just before the update, the busy window of every channel it wakes is PU_ALL_CYC cycles.
- R12: An update to a channel that is already enabled starts no busy window. Commands taken while a channel is busy are applied at once.
- R13: The word layout is operation in bits [23:20], address in [19:16] and data in [15:0]. A word is taken at each rising edge where `cmd_valid` and `cmd_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Block can take a word (high out of reset) |
| cmd_word | input | 24 | Operation, address, data |
| dac_code | output | NCH*RES (48) | Active codes, channel A in the lowest bits |
| ch_en | output | NCH (4) | Per-channel enabled (powered up) |
| ch_busy | output | NCH (4) | Per-channel settling window in progress |

## Verification
The bench aims at the write-then-update-all operation. Here the addressed channel must receive the new word while the other channels take their older staging values; a design that updated before writing would put a stale code on the addressed channel. It wakes channels from the all-asleep state and from a partly asleep state. Swapping the two delays, or counting one cycle off, shows up as a busy flag that falls on the wrong sample. Power-down followed by an update checks that no register was cleared. Reserved operations and reserved addresses mixed in at random would show as code or enable changes in a design that decoded them loosely.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
  localparam int DATA_W = 16;
  localparam int CMD_W  = 24;

  localparam logic [3:0] OP_WRITE         = 4'h0;
  localparam logic [3:0] OP_UPDATE        = 4'h1;
  localparam logic [3:0] OP_WRITE_UPD_ALL = 4'h2;
  localparam logic [3:0] OP_WRITE_UPD     = 4'h3;
  localparam logic [3:0] OP_PWR_DOWN      = 4'h4;
  localparam logic [3:0] OP_NOP           = 4'hF;
  localparam logic [3:0] ADDR_ALL         = 4'hF;

  typedef struct packed {
    logic [3:0]        op;
    logic [3:0]        addr;
    logic [DATA_W-1:0] data;
  } cmd_word_t;
endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_ctrl_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           valid,
  input  cmd_word_t      word,
  output logic [NCH-1:0] wr_mask,
  output logic [NCH-1:0] upd_mask,
  output logic [NCH-1:0] pd_mask,
  output logic           reserved
);
  logic [NCH-1:0] sel;
  logic           addr_ok;
  logic           op_ok;

  always_comb begin
    sel     = '0;
    addr_ok = 1'b0;
    if (word.addr == ADDR_ALL) begin
      sel     = '1;
      addr_ok = 1'b1;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (word.addr == 4'(i)) begin
          sel[i]  = 1'b1;
          addr_ok = 1'b1;
        end
      end
    end
  end

  always_comb begin
    wr_mask  = '0;
    upd_mask = '0;
    pd_mask  = '0;
    op_ok    = 1'b1;
    case (word.op)
      OP_WRITE:         wr_mask = sel;
      OP_UPDATE:        upd_mask = sel;
      OP_WRITE_UPD_ALL: begin wr_mask = sel; upd_mask = '1; end
      OP_WRITE_UPD:     begin wr_mask = sel; upd_mask = sel; end
      OP_PWR_DOWN:      pd_mask = sel;
      OP_NOP:           ;
      default:          op_ok = 1'b0;
    endcase
    if (!valid || !addr_ok || !op_ok) begin
      wr_mask  = '0;
      upd_mask = '0;
      pd_mask  = '0;
    end
    reserved = valid && !(addr_ok && op_ok);
  end
endmodule

// File: rtl/dac_settle_timer.sv
module dac_settle_timer #(
  parameter int PU_CYC     = 6,
  parameter int PU_ALL_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic all_down,
  input  logic stop,
  output logic busy
);
  localparam int MAXC = (PU_ALL_CYC > PU_CYC) ? PU_ALL_CYC : PU_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (stop)        cnt <= '0;
    else if (start)       cnt <= all_down ? CW'(PU_ALL_CYC) : CW'(PU_CYC);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R10
  busy_rise_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/dac_channel.sv
module dac_channel
  import dac_ctrl_pkg::*;
#(
  parameter int RES        = 12,
  parameter int PU_CYC     = 6,
  parameter int PU_ALL_CYC = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              upd,
  input  logic              pd,
  input  logic [DATA_W-1:0] data,
  input  logic              all_down,
  output logic [RES-1:0]    code,
  output logic              en,
  output logic              busy
);
  logic [RES-1:0] stage_q;
  logic [RES-1:0] stage_nx;
  logic           wake;

  assign stage_nx = wr ? data[DATA_W-1 -: RES] : stage_q;
  assign wake     = upd && !en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      code    <= '0;
      en      <= 1'b0;
    end else begin
      if (wr)  stage_q <= stage_nx;
      if (upd) begin
        code <= stage_nx;
        en   <= 1'b1;
      end
      if (pd)  en <= 1'b0;
    end
  end

  dac_settle_timer #(.PU_CYC(PU_CYC), .PU_ALL_CYC(PU_ALL_CYC)) i_timer (
    .clk(clk), .rst_n(rst_n), .start(wake), .all_down(all_down),
    .stop(pd), .busy(busy)
  );

  // R6
  pd_keeps_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> $stable(code) && !en && !busy);
  // R12
  busy_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> en);
  // R3
  upd_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd && !pd |=> en);
endmodule

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl
  import dac_ctrl_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int RES        = 12,
  parameter int PU_CYC     = 6,
  parameter int PU_ALL_CYC = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [CMD_W-1:0]   cmd_word,
  output logic [NCH*RES-1:0] dac_code,
  output logic [NCH-1:0]     ch_en,
  output logic [NCH-1:0]     ch_busy
);
  cmd_word_t      word;
  logic           take;
  logic [NCH-1:0] wr_mask, upd_mask, pd_mask;
  logic           reserved;
  logic           all_down;

  assign cmd_ready = rst_n;
  assign take      = cmd_valid && cmd_ready;
  assign word      = cmd_word_t'(cmd_word);
  assign all_down  = (ch_en == '0);

  dac_cmd_decode #(.NCH(NCH)) i_dec (
    .valid(take), .word(word), .wr_mask(wr_mask), .upd_mask(upd_mask),
    .pd_mask(pd_mask), .reserved(reserved)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dac_channel #(.RES(RES), .PU_CYC(PU_CYC), .PU_ALL_CYC(PU_ALL_CYC)) i_ch (
      .clk(clk), .rst_n(rst_n), .wr(wr_mask[c]), .upd(upd_mask[c]),
      .pd(pd_mask[c]), .data(word.data), .all_down(all_down),
      .code(dac_code[c*RES +: RES]), .en(ch_en[c]), .busy(ch_busy[c])
    );
  end

  // R7
  reserved_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reserved |=> $stable(dac_code) && $stable(ch_en));
  // R2
  write_only_keeps_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && word.op == OP_WRITE |=> $stable(dac_code) && $stable(ch_en));
endmodule

// File: tb/test_quad_dac_ctrl.sv
module test_quad_dac_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 4;
  localparam int RES   = 12;
  localparam int PU    = 6;
  localparam int PUALL = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [23:0] cmd_word = '0;
  logic cmd_ready;
  logic [NCH*RES-1:0] dac_code;
  logic [NCH-1:0] ch_en, ch_busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_dac_ctrl #(.NCH(NCH), .RES(RES), .PU_CYC(PU), .PU_ALL_CYC(PUALL)) i_quad_dac_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .dac_code(dac_code), .ch_en(ch_en), .ch_busy(ch_busy)
  );

  logic [RES-1:0] in_m [NCH];
  logic [RES-1:0] dac_m [NCH];
  logic           en_m [NCH];
  int             cnt_m [NCH];
  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic exp_ready);
    logic [NCH*RES-1:0] ec;
    logic [NCH-1:0] ee, eb;
    for (int c = 0; c < NCH; c++) begin
      ec[c*RES +: RES] = dac_m[c];
      ee[c] = en_m[c];
      eb[c] = (cnt_m[c] > 0);
    end
    check(tag, "dac_code", 64'(dac_code), 64'(ec));
    check(tag, "ch_en", 64'(ch_en), 64'(ee));
    check(tag, "ch_busy", 64'(ch_busy), 64'(eb));
    check(tag, "cmd_ready", 64'(cmd_ready), 64'(exp_ready));
  endtask

  // Reference model from the requirements
  task automatic model_apply(input logic v, input logic [23:0] w);
    logic [3:0] op, ad;
    logic [15:0] d;
    logic [NCH-1:0] sel, wrm, updm, pdm;
    logic ok, alldn;
    logic [RES-1:0] nx;
    op = w[23:20]; ad = w[19:16]; d = w[15:0];
    sel = '0; ok = 1'b1;
    if (ad == 4'hF) sel = '1;
    else if (ad < NCH) sel[ad[1:0]] = 1'b1;
    else ok = 1'b0;
    wrm = '0; updm = '0; pdm = '0;
    if (v && ok) begin
      case (op)
        4'h0: wrm = sel;
        4'h1: updm = sel;
        4'h2: begin wrm = sel; updm = '1; end
        4'h3: begin wrm = sel; updm = sel; end
        4'h4: pdm = sel;
        default: ;
      endcase
    end
    alldn = 1'b1;
    for (int c = 0; c < NCH; c++) if (en_m[c]) alldn = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      nx = wrm[c] ? d[15 -: RES] : in_m[c];
      if (pdm[c]) begin
        en_m[c] = 1'b0;
        cnt_m[c] = 0;
      end else begin
        if (updm[c] && !en_m[c]) cnt_m[c] = alldn ? PUALL : PU;
        else if (cnt_m[c] > 0) cnt_m[c] = cnt_m[c] - 1;
        if (updm[c]) begin
          dac_m[c] = nx;
          en_m[c] = 1'b1;
        end
      end
      in_m[c] = nx;
    end
  endtask

  task automatic step(input logic v, input logic [23:0] w, input string tag);
    cmd_valid = v;
    cmd_word = w;
    @(posedge clk);
    model_apply(v, w);
    @(negedge clk);
    cmd_valid = 1'b0;
    check_all(tag, 1'b1);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 24'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [3:0] op, ad;
    int r;
    string tg;
    void'($urandom(32'd2024));
    for (int c = 0; c < NCH; c++) begin
      in_m[c] = '0; dac_m[c] = '0; en_m[c] = 1'b0; cnt_m[c] = 0;
    end
    repeat (3) @(negedge clk);
    check_all("R1", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1", 1'b1);

    step(1'b1, {4'h0, 4'h0, 16'hABCD}, "R2");
    step(1'b1, {4'h1, 4'h0, 16'h0000}, "R3");
    idle(PUALL + 1, "R11");
    step(1'b1, {4'h3, 4'h1, 16'h1234}, "R5");
    idle(PU + 1, "R10");
    step(1'b1, {4'h3, 4'h1, 16'h5678}, "R12");
    step(1'b1, {4'h3, 4'h2, 16'h987F}, "R9");
    idle(PU, "R9");
    step(1'b1, {4'h0, 4'h0, 16'h1111}, "R2");
    step(1'b1, {4'h2, 4'h3, 16'h4444}, "R4");
    idle(PU + 1, "R4");
    step(1'b1, {4'h4, 4'hF, 16'hFFFF}, "R6");
    step(1'b1, {4'h1, 4'hF, 16'h0000}, "R6");
    idle(PUALL + 1, "R11");
    step(1'b1, {4'h5, 4'h2, 16'hDEAD}, "R7");
    step(1'b1, {4'h3, 4'h7, 16'hBEEF}, "R7");
    step(1'b1, {4'hF, 4'h0, 16'hBEEF}, "R7");
    step(1'b1, {4'h4, 4'h2, 16'h0000}, "R8");
    step(1'b1, {4'h0, 4'hF, 16'h2222}, "R8");
    step(1'b1, {4'h1, 4'h2, 16'h0000}, "R10");
    step(1'b1, {4'h3, 4'h0, 16'h3333}, "R12");
    step(1'b1, {4'h4, 4'h2, 16'h0000}, "R6");
    step(1'b1, {4'h1, 4'hF, 16'h0000}, "R8");
    idle(PU + 1, "R10");

    for (int k = 0; k < 600; k++) begin
      r = $urandom % 10;
      case (r)
        0, 1: op = 4'h0;
        2:    op = 4'h1;
        3:    op = 4'h2;
        4, 5: op = 4'h3;
        6:    op = 4'h4;
        7:    op = 4'hF;
        default: op = 4'(5 + ($urandom % 10));
      endcase
      if (($urandom % 8) < 6) ad = 4'($urandom % 4);
      else ad = ($urandom % 2 == 0) ? 4'hF : 4'(4 + ($urandom % 11));
      case (op)
        4'h0: tg = "R2";
        4'h1: tg = "R3";
        4'h2: tg = "R4";
        4'h3: tg = "R5";
        4'h4: tg = "R6";
        default: tg = "R7";
      endcase
      if (r == 9) step(1'b0, 24'h0, "R13");
      else step(1'b1, {op, ad, 16'($urandom)}, tg);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule